// File: doc/BRIEF.md
# x86 Instruction Prefix and Opcode Scanner

This block takes the byte stream of one x86 instruction, one byte per cycle in which `byte_vld` is high, and walks over the legacy and REX prefixes until it reaches the primary opcode. It records the effective operand and address sizes and the repeat byte. It also records the lock flag, the segment override, the four REX bits, the opcode, the secondary opcode after a 0x0F escape, and the number of prefix bytes consumed.

A later stage uses these results to look up the opcode tables, decode ModR/M and compute the instruction length. The `long_mode` input decides whether bytes 0x40..0x4F are REX prefixes (long mode) or ordinary opcodes (protected mode).

The owner pulses `start` before each instruction. It then feeds bytes until `done` rises. All results hold steady until the next `start`.

Top module: `ipfx_scanner`

## Requirements
- R1: After reset, or after the cycle following a `start` pulse, all outputs are at their defaults. Operand and address sizes read 32 bits. The override flags, lock, REX bits, escape and done read 0. The repeat byte, opcode, secondary opcode and count read 0. The segment code reads 0xFF. Size encoding: 0 = 16 bits, 1 = 32 bits, 2 = 64 bits.
- R2: Each 0x66 byte switches the operand size from 32 to 16 or from 16 to 32, and sets `opsz_ovr`. A size of 64 is left unchanged. Each 0x67 byte switches the address size between 32 and 16 in the same way, and sets `adsz_ovr`.
- R3: Bytes 0xF2 and 0xF3 are repeat prefixes, and `rep_byte` holds the last one seen. Byte 0xF0 sets `lock`.
- R4: In long mode, a byte 0x40..0x4F is a REX prefix. Its bit 3 drives W, bit 2 drives R, bit 1 drives X and bit 0 drives B, and each REX byte overwrites these four bits. A REX byte with W=1 sets the operand size to 64, and the size stays 64 until the next `start`. In protected mode, such a byte is the opcode.
- R5: Segment override bytes set `seg_code` as follows: 0x26 gives 0, 0x2E gives 1, 0x36 gives 2, 0x3E gives 3, 0x64 gives 4 and 0x65 gives 5. The last override seen wins. With no override, the code stays 0xFF.
- R6: The first non-prefix byte is the opcode. If it is 0x0F, `escape` is set and the next valid byte is taken as the secondary opcode. Otherwise the secondary opcode stays 0.
- R7: `pfx_cnt` counts the prefix bytes consumed and saturates at 15.
- R8: `done` is high for exactly one cycle, right after the clock edge that accepts the opcode (or the secondary opcode). Cycles with `byte_vld` low change nothing. Bytes after completion are ignored until `start`.
- R9: `start` restores the defaults and takes priority over a byte presented in the same cycle, which is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Restore defaults for a new instruction |
| long_mode | input | 1 | 1 = long mode, 0 = protected mode |
| byte_vld | input | 1 | Instruction byte valid this cycle |
| byte_in | input | 8 | Instruction byte |
| done | output | 1 | One-cycle pulse: scan complete |
| opsz | output | 2 | Operand size code (0=16, 1=32, 2=64) |
| adsz | output | 2 | Address size code (0=16, 1=32) |
| opsz_ovr | output | 1 | An operand-size override was seen |
| adsz_ovr | output | 1 | An address-size override was seen |
| rep_byte | output | 8 | Last repeat prefix byte, 0 if none |
| lock | output | 1 | Lock prefix seen |
| seg_code | output | 8 | Segment override code, 0xFF if none |
| rex_w | output | 1 | REX W bit |
| rex_r | output | 1 | REX R bit |
| rex_x | output | 1 | REX X bit |
| rex_b | output | 1 | REX B bit |
| opcode | output | 8 | Primary opcode byte |
| opcode2 | output | 8 | Secondary opcode after 0x0F |
| escape | output | 1 | Primary opcode was 0x0F |
| pfx_cnt | output | 4 | Prefix bytes consumed, saturating |

## Verification
On every cycle, the assertions check the following:
- `done` never stays high for two cycles.
- The segment code and the repeat byte only take legal values.
- A saturated count stays saturated.
- A `start` pulse always leaves the defaults one cycle later.

Only the bench scenarios can show the following:
- Which byte values count as prefixes in each mode.
- That size toggling is correct across repeated overrides.
- That the last repeat or segment byte wins.
- That REX W makes the 64-bit size sticky.
- That the byte sent with `start` is dropped.
- That bytes sent after completion are ignored.

// File: rtl/ipfx_pkg.sv
package ipfx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SZ16 = 2'd0,
        SZ32 = 2'd1,
        SZ64 = 2'd2
    } size_e;

    typedef enum logic [2:0] {
        K_OPSZ,
        K_ADSZ,
        K_REP,
        K_LOCK,
        K_REX,
        K_SEG,
        K_ESC,
        K_OPC
    } kind_e;

    typedef enum logic [1:0] {
        ST_PFX,
        ST_ESC,
        ST_HOLD
    } state_e;

    localparam logic [BYTE_W-1:0] SEG_NONE = 8'hFF;
endpackage

// File: rtl/ipfx_seg_map.sv
module ipfx_seg_map
    import ipfx_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output logic              hit,
    output logic [2:0]        code
);
    always_comb begin
        hit  = 1'b1;
        code = 3'd0;
        case (byte_in)
            8'h26: code = 3'd0;
            8'h2E: code = 3'd1;
            8'h36: code = 3'd2;
            8'h3E: code = 3'd3;
            8'h64: code = 3'd4;
            8'h65: code = 3'd5;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ipfx_classify.sv
module ipfx_classify
    import ipfx_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              long_mode,
    input  logic              seg_hit,
    output kind_e             kind
);
    always_comb begin
        if (byte_in == 8'h66)                          kind = K_OPSZ;
        else if (byte_in == 8'h67)                     kind = K_ADSZ;
        else if (byte_in == 8'hF2 || byte_in == 8'hF3) kind = K_REP;
        else if (byte_in == 8'hF0)                     kind = K_LOCK;
        else if (long_mode && byte_in[7:4] == 4'h4)    kind = K_REX;
        else if (seg_hit)                              kind = K_SEG;
        else if (byte_in == 8'h0F)                     kind = K_ESC;
        else                                           kind = K_OPC;
    end
endmodule

// File: rtl/ipfx_size_step.sv
module ipfx_size_step
    import ipfx_pkg::*;
(
    input  size_e cur,
    output size_e flipped
);
    always_comb begin
        case (cur)
            SZ32:    flipped = SZ16;
            SZ16:    flipped = SZ32;
            default: flipped = cur;
        endcase
    end
endmodule

// File: rtl/ipfx_scanner.sv
module ipfx_scanner
    import ipfx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              long_mode,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    output logic              done,
    output logic [1:0]        opsz,
    output logic [1:0]        adsz,
    output logic              opsz_ovr,
    output logic              adsz_ovr,
    output logic [7:0]        rep_byte,
    output logic              lock,
    output logic [7:0]        seg_code,
    output logic              rex_w,
    output logic              rex_r,
    output logic              rex_x,
    output logic              rex_b,
    output logic [7:0]        opcode,
    output logic [7:0]        opcode2,
    output logic              escape,
    output logic [CNT_W-1:0]  pfx_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        state_e            st;
        logic              done;
        size_e             osz;
        size_e             asz;
        logic              oovr;
        logic              aovr;
        logic [BYTE_W-1:0] rep;
        logic              lck;
        logic [BYTE_W-1:0] seg;
        logic [3:0]        rex;
        logic [BYTE_W-1:0] opc;
        logic [BYTE_W-1:0] opc2;
        logic              esc;
        logic [CNT_W-1:0]  cnt;
    } scan_t;

    localparam scan_t DEFAULTS = '{
        st: ST_PFX, done: 1'b0, osz: SZ32, asz: SZ32, oovr: 1'b0, aovr: 1'b0,
        rep: '0, lck: 1'b0, seg: SEG_NONE, rex: 4'd0, opc: '0, opc2: '0,
        esc: 1'b0, cnt: '0
    };

    scan_t s_d, s_q;

    logic  seg_hit;
    logic [2:0] seg_val;
    kind_e kind;
    size_e osz_flip, asz_flip;

    ipfx_seg_map u_seg (.byte_in(byte_in), .hit(seg_hit), .code(seg_val));
    ipfx_classify u_cls (.byte_in(byte_in), .long_mode(long_mode), .seg_hit(seg_hit), .kind(kind));
    ipfx_size_step u_ostep (.cur(s_q.osz), .flipped(osz_flip));
    ipfx_size_step u_astep (.cur(s_q.asz), .flipped(asz_flip));

    logic [CNT_W-1:0] cnt_inc;
    assign cnt_inc = (s_q.cnt == CNT_MAX) ? CNT_MAX : s_q.cnt + 1'b1;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (start) begin
            s_d = DEFAULTS;
        end else if (byte_vld) begin
            case (s_q.st)
                ST_PFX: begin
                    case (kind)
                        K_OPSZ: begin
                            s_d.osz  = osz_flip;
                            s_d.oovr = 1'b1;
                            s_d.cnt  = cnt_inc;
                        end
                        K_ADSZ: begin
                            s_d.asz  = asz_flip;
                            s_d.aovr = 1'b1;
                            s_d.cnt  = cnt_inc;
                        end
                        K_REP: begin
                            s_d.rep = byte_in;
                            s_d.cnt = cnt_inc;
                        end
                        K_LOCK: begin
                            s_d.lck = 1'b1;
                            s_d.cnt = cnt_inc;
                        end
                        K_REX: begin
                            s_d.rex = byte_in[3:0];
                            if (byte_in[3]) s_d.osz = SZ64;
                            s_d.cnt = cnt_inc;
                        end
                        K_SEG: begin
                            s_d.seg = {5'd0, seg_val};
                            s_d.cnt = cnt_inc;
                        end
                        K_ESC: begin
                            s_d.opc = byte_in;
                            s_d.esc = 1'b1;
                            s_d.st  = ST_ESC;
                        end
                        default: begin
                            s_d.opc  = byte_in;
                            s_d.st   = ST_HOLD;
                            s_d.done = 1'b1;
                        end
                    endcase
                end
                ST_ESC: begin
                    s_d.opc2 = byte_in;
                    s_d.st   = ST_HOLD;
                    s_d.done = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= DEFAULTS;
        else        s_q <= s_d;
    end

    assign done     = s_q.done;
    assign opsz     = s_q.osz;
    assign adsz     = s_q.asz;
    assign opsz_ovr = s_q.oovr;
    assign adsz_ovr = s_q.aovr;
    assign rep_byte = s_q.rep;
    assign lock     = s_q.lck;
    assign seg_code = s_q.seg;
    assign rex_w    = s_q.rex[3];
    assign rex_r    = s_q.rex[2];
    assign rex_x    = s_q.rex[1];
    assign rex_b    = s_q.rex[0];
    assign opcode   = s_q.opc;
    assign opcode2  = s_q.opc2;
    assign escape   = s_q.esc;
    assign pfx_cnt  = s_q.cnt;

    // R8: completion is signalled for a single cycle only
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: segment output is either the no-override code or a legal register
    p_seg_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_code == 8'hFF) || (seg_code <= 8'd5));

    // R3: the repeat byte only ever holds a repeat prefix value or zero
    p_rep_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_byte == 8'h00) || (rep_byte == 8'hF2) || (rep_byte == 8'hF3));

    // R7: a saturated count never wraps back down without a start
    p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pfx_cnt == CNT_MAX && !start) |=> (pfx_cnt == CNT_MAX));

    // R9: start always leaves the default state behind it
    p_start_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (opsz == 2'd1 && adsz == 2'd1 && pfx_cnt == '0 &&
                   seg_code == 8'hFF && !lock && !escape && !done));
endmodule

// File: tb/tb_ipfx_scanner.sv
module tb_ipfx_scanner;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic long_mode = 1'b0;
    logic byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic done, opsz_ovr, adsz_ovr, lock, rex_w, rex_r, rex_x, rex_b, escape;
    logic [1:0] opsz, adsz;
    logic [7:0] rep_byte, seg_code, opcode, opcode2;
    logic [3:0] pfx_cnt;

    always #4 clk = ~clk;

    ipfx_scanner dut (
        .clk(clk), .rst_n(rst_n), .start(start), .long_mode(long_mode),
        .byte_vld(byte_vld), .byte_in(byte_in), .done(done), .opsz(opsz),
        .adsz(adsz), .opsz_ovr(opsz_ovr), .adsz_ovr(adsz_ovr),
        .rep_byte(rep_byte), .lock(lock), .seg_code(seg_code),
        .rex_w(rex_w), .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b),
        .opcode(opcode), .opcode2(opcode2), .escape(escape), .pfx_cnt(pfx_cnt)
    );

    int checks = 0;
    int failures = 0;

    // bench model state
    logic [1:0] m_osz, m_asz;
    logic m_oovr, m_aovr, m_lck, m_esc, m_done;
    logic [7:0] m_rep, m_seg, m_opc, m_opc2;
    logic [3:0] m_rex, m_cnt;
    int m_phase; // 0 prefixes, 1 waiting secondary, 2 finished

    task automatic m_clear();
        m_osz = 2'd1; m_asz = 2'd1; m_oovr = 0; m_aovr = 0; m_lck = 0;
        m_esc = 0; m_done = 0; m_rep = 0; m_seg = 8'hFF; m_opc = 0;
        m_opc2 = 0; m_rex = 0; m_cnt = 0; m_phase = 0;
    endtask

    function automatic int seg_of(input logic [7:0] b);
        case (b)
            8'h26: return 0; 8'h2E: return 1; 8'h36: return 2;
            8'h3E: return 3; 8'h64: return 4; 8'h65: return 5;
            default: return -1;
        endcase
    endfunction

    task automatic m_byte(input logic [7:0] b, input logic lm);
        bit pfx;
        m_done = 0;
        if (m_phase == 2) return;
        if (m_phase == 1) begin
            m_opc2 = b; m_phase = 2; m_done = 1; return;
        end
        pfx = 1;
        if (b == 8'h66) begin
            m_oovr = 1;
            if (m_osz == 2'd1) m_osz = 2'd0; else if (m_osz == 2'd0) m_osz = 2'd1;
        end else if (b == 8'h67) begin
            m_aovr = 1;
            m_asz = (m_asz == 2'd1) ? 2'd0 : 2'd1;
        end else if (b == 8'hF2 || b == 8'hF3) m_rep = b;
        else if (b == 8'hF0) m_lck = 1;
        else if (lm && b >= 8'h40 && b <= 8'h4F) begin
            m_rex = b[3:0];
            if (b[3]) m_osz = 2'd2;
        end else if (seg_of(b) >= 0) m_seg = 8'(seg_of(b));
        else pfx = 0;
        if (pfx) begin
            if (m_cnt != 4'd15) m_cnt = m_cnt + 1;
        end else begin
            m_opc = b;
            if (b == 8'h0F) begin m_esc = 1; m_phase = 1; end
            else begin m_phase = 2; m_done = 1; end
        end
    endtask

    function automatic logic [48:0] act_vec();
        return {opsz, adsz, opsz_ovr, adsz_ovr, rep_byte, lock, seg_code,
                rex_w, rex_r, rex_x, rex_b, opcode, opcode2, escape, pfx_cnt, done};
    endfunction

    function automatic logic [48:0] exp_vec();
        return {m_osz, m_asz, m_oovr, m_aovr, m_rep, m_lck, m_seg,
                m_rex, m_opc, m_opc2, m_esc, m_cnt, m_done};
    endfunction

    task automatic check(input string req);
        checks++;
        if (act_vec() !== exp_vec()) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act_vec(), exp_vec());
        end
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        m_clear();
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); byte_vld = 1'b1; byte_in = b;
        @(negedge clk); byte_vld = 1'b0;
        m_byte(b, long_mode);
    endtask

    task automatic idle_check(input string req);
        @(negedge clk);
        m_done = 0;
        check(req);
    endtask

    initial begin
        #(8 * 190000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset defaults");

        // R4 R6 R7: sweep every byte as first byte in both modes
        for (int mode = 0; mode < 2; mode++) begin
            long_mode = mode[0];
            for (int b = 0; b < 256; b++) begin
                do_start();
                check("R1 defaults after start");
                send(8'(b));
                check("R6 first byte sweep");
                if (!m_done) begin
                    send(8'h90);
                    check("R6 follow byte sweep");
                end
                idle_check("R8 done drops");
            end
        end

        long_mode = 1'b0;
        // R2: toggling
        do_start();
        send(8'h66); check("R2 opsz to 16");
        send(8'h66); check("R2 opsz back to 32");
        send(8'h67); check("R2 adsz to 16");
        send(8'h66); send(8'h67); check("R2 mixed toggles");
        send(8'h01); check("R2 final opcode");

        // R3: repeat last wins, lock
        do_start();
        send(8'hF3); send(8'hF2); check("R3 last repeat F2");
        send(8'hF0); send(8'hF3); check("R3 lock and F3");
        send(8'hA5); check("R3 opcode");

        // R5: segment overrides, last wins
        do_start();
        send(8'h26); check("R5 ES");
        send(8'h65); check("R5 GS wins");
        send(8'h3E); send(8'h8B); check("R5 DS opcode");

        // R4: REX sticky 64 and overwrite
        long_mode = 1'b1;
        do_start();
        send(8'h66); check("R4 16 before rex");
        send(8'h48); check("R4 W forces 64");
        send(8'h66); check("R4 66 leaves 64");
        send(8'h45); check("R4 rex overwrite keeps 64");
        send(8'h89); check("R4 opcode long");
        long_mode = 1'b0;
        do_start();
        send(8'h48); check("R4 protected rex is opcode");

        // R6: escape and secondary
        do_start();
        send(8'h66); send(8'h0F); check("R6 escape pending");
        send(8'h38); check("R6 secondary taken");
        idle_check("R6 held");

        // R7: saturation
        do_start();
        for (int i = 0; i < 18; i++) begin
            send((i % 2 == 0) ? 8'h2E : 8'hF0);
        end
        check("R7 count saturates");
        send(8'hC3); check("R7 opcode after saturation");

        // R8: valid low gaps and ignore after completion
        do_start();
        send(8'hF3);
        repeat (3) @(negedge clk);
        check("R8 gap changes nothing");
        send(8'hA4); check("R8 completes");
        send(8'h66); check("R8 ignored after done");
        send(8'h0F); check("R8 still ignored");

        // R9: start has priority over simultaneous byte
        do_start();
        send(8'h66);
        @(negedge clk); start = 1'b1; byte_vld = 1'b1; byte_in = 8'h90;
        @(negedge clk); start = 1'b0; byte_vld = 1'b0;
        m_clear();
        check("R9 start drops byte");
        send(8'h0F); send(8'h05); check("R9 fresh scan after start");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule